// File: doc/BRIEF.md
# Video Standard Hunting Selector

This block sets a 2-bit standard-select code for a serial video receiver while the system looks for the data rate of the incoming stream. A hunt timer counts clock cycles. At the end of each hunt period, a binary code counter moves to the next of the four standards. When the attached decoder finds a valid timing preamble, hunting stops. Hunting also stops while the receiver reports no carrier. In both cases the code on the outputs stays as it is.

A preamble pulse starts a lock window that lasts a configurable number of hunt periods. Each further pulse starts the window again. When the window runs out with no new pulse, hunting resumes. The hunt timer then restarts from zero, so the first step after resuming always takes one full period.

Top module: `std_hunt_sel`

## Requirements
- R1: While reset is asserted and right after it is released, the code is 00 and the block is hunting with its timer at zero.
- R2: While hunting with carrier present, the code steps by one in the order 00, 01, 10, 11, 00. The codes stand for 4:2:2 at 270 Mb/s, 4:2:2 at 360 Mb/s, 4fsc NTSC and 4fsc PAL. Port `sel_hi` is code bit 1 and `sel_lo` is code bit 0.
- R3: The hunt period is `hunt_len` clock cycles. A value of 0 acts as 1. With the timer at zero, the step happens on the `hunt_len`-th rising edge.
- R4: While `carrier_ok` is low, the code holds and the hunt timer is held at zero. After the carrier returns, the first step comes a full period later.
- R5: A cycle with `preamble_ok` high never steps the code, even when a step was due in that cycle. It also clears the hunt timer.
- R6: After the last preamble pulse, the code holds for `lock_periods` full hunt periods. A value of 0 acts as 1. Each new pulse starts this window again. While the carrier is absent, the window does not run down.
- R7: When the lock window expires, hunting resumes. The first step comes exactly one full hunt period after expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_ok | input | 1 | Receiver reports a carrier present |
| preamble_ok | input | 1 | One-cycle pulse per valid timing preamble |
| hunt_len | input | PERIOD_W | Hunt period in clock cycles |
| lock_periods | input | LOCK_W | Lock window in hunt periods |
| sel_hi | output | 1 | Standard-select code bit 1 |
| sel_lo | output | 1 | Standard-select code bit 0 |

## Verification
The code counter is the only state visible at the ports. A fault in the timer or in the lock window shows up only as a step at the wrong edge. The bench therefore checks the code one cycle before each step is due and again at the due edge. With those checks, an off-by-one in the timer, in the lock window or in the freeze logic is caught within a single hunt period. A lock state that is wrong either holds the code after expiry or steps it during the window, so the error shows within `lock_periods`+1 periods.

// File: rtl/std_hunt_pkg.sv
package std_hunt_pkg;
  typedef enum logic [1:0] {
    STD_422_270 = 2'b00,
    STD_422_360 = 2'b01,
    STD_NTSC    = 2'b10,
    STD_PAL     = 2'b11
  } std_code_e;

  function automatic std_code_e next_code(input std_code_e c);
    return std_code_e'(c + 2'd1);
  endfunction
endpackage

// File: rtl/hunt_timer.sv
module hunt_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] hunt_len,
  output logic                tick
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] tmr;
  logic [PERIOD_W-1:0] last;

  function automatic logic [PERIOD_W-1:0] last_count(input logic [PERIOD_W-1:0] len);
    return (len == '0) ? '0 : len - ONE;
  endfunction

  assign last = last_count(hunt_len);
  assign tick = run && (tmr >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)      tmr <= '0;
    else if (!run)   tmr <= '0;
    else if (tick)   tmr <= '0;
    else             tmr <= tmr + ONE;
  end

  assert_timer_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tmr == '0));
  assert_timer_no_tick_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preamble_ok,
  input  logic              period_tick,
  input  logic [LOCK_W-1:0] lock_periods,
  output logic              locked
);
  localparam logic [LOCK_W-1:0] ONE = LOCK_W'(1);

  logic [LOCK_W-1:0] left;

  function automatic logic [LOCK_W-1:0] window_load(input logic [LOCK_W-1:0] n);
    return (n == '0) ? ONE : n;
  endfunction

  assign locked = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                    left <= '0;
    else if (preamble_ok)          left <= window_load(lock_periods);
    else if (period_tick && locked) left <= left - ONE;
  end

  assert_pulse_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    preamble_ok |=> locked);
  assert_window_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !period_tick && !preamble_ok) |=> locked);
endmodule

// File: rtl/code_counter.sv
module code_counter
  import std_hunt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  output std_code_e code
);
  always_ff @(posedge clk) begin
    if (!rst_n)    code <= STD_422_270;
    else if (step) code <= next_code(code);
  end

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> (code == std_code_e'($past(code) + 2'd1)));
  assert_hold_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(code));
endmodule

// File: rtl/std_hunt_sel.sv
module std_hunt_sel
  import std_hunt_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int LOCK_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                carrier_ok,
  input  logic                preamble_ok,
  input  logic [PERIOD_W-1:0] hunt_len,
  input  logic [LOCK_W-1:0]   lock_periods,
  output logic                sel_hi,
  output logic                sel_lo
);
  logic      timer_run;
  logic      period_tick;
  logic      locked;
  logic      step;
  std_code_e code;

  assign timer_run = carrier_ok && !preamble_ok;
  assign step      = period_tick && !locked;

  hunt_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run),
    .hunt_len(hunt_len), .tick(period_tick)
  );

  lock_watch #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .preamble_ok(preamble_ok),
    .period_tick(period_tick), .lock_periods(lock_periods), .locked(locked)
  );

  code_counter u_code (
    .clk(clk), .rst_n(rst_n), .step(step), .code(code)
  );

  assign sel_hi = code[1];
  assign sel_lo = code[0];

  assert_no_step_without_carrier_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_ok |=> $stable({sel_hi, sel_lo}));
  assert_no_step_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    preamble_ok |=> $stable({sel_hi, sel_lo}));
  assert_no_step_while_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable({sel_hi, sel_lo}));
endmodule

// File: tb/std_hunt_sel_bench.sv
module std_hunt_sel_bench;
  localparam int PW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          carrier_ok = 1'b0;
  logic          preamble_ok = 1'b0;
  logic [PW-1:0] hunt_len = PW'(4);
  logic [LW-1:0] lock_periods = LW'(2);
  logic          sel_hi, sel_lo;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  std_hunt_sel #(.PERIOD_W(PW), .LOCK_W(LW)) u_std_hunt_sel (
    .clk(clk), .rst_n(rst_n), .carrier_ok(carrier_ok), .preamble_ok(preamble_ok),
    .hunt_len(hunt_len), .lock_periods(lock_periods), .sel_hi(sel_hi), .sel_lo(sel_lo)
  );

  // {carrier, preamble, edges to run, expected code} ; period 4, lock window 2
  localparam int NV = 23;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd3,  2'd0},  // R3 no step before 4th edge
    {1'b1, 1'b0, 8'd1,  2'd1},  // R2 R3 step
    {1'b1, 1'b0, 8'd4,  2'd2},  // R2
    {1'b1, 1'b0, 8'd4,  2'd3},  // R2
    {1'b1, 1'b0, 8'd4,  2'd0},  // R2 wrap
    {1'b1, 1'b0, 8'd2,  2'd0},
    {1'b0, 1'b0, 8'd5,  2'd0},  // R4 hold, timer cleared
    {1'b1, 1'b0, 8'd3,  2'd0},  // R4 full period after return
    {1'b1, 1'b0, 8'd1,  2'd1},  // R4
    {1'b1, 1'b0, 8'd3,  2'd1},
    {1'b1, 1'b1, 8'd1,  2'd1},  // R5 pulse on due edge
    {1'b1, 1'b0, 8'd8,  2'd1},  // R6 window of 2 periods
    {1'b1, 1'b0, 8'd3,  2'd1},  // R7
    {1'b1, 1'b0, 8'd1,  2'd2},  // R7 step one period after expiry
    {1'b1, 1'b1, 8'd1,  2'd2},  // R5
    {1'b1, 1'b0, 8'd6,  2'd2},  // R6
    {1'b1, 1'b1, 8'd1,  2'd2},  // R6 restart
    {1'b1, 1'b0, 8'd11, 2'd2},  // R6 restarted window
    {1'b1, 1'b0, 8'd1,  2'd3},  // R7
    {1'b1, 1'b1, 8'd1,  2'd3},  // R6
    {1'b0, 1'b0, 8'd10, 2'd3},  // R6 window frozen without carrier
    {1'b1, 1'b0, 8'd11, 2'd3},  // R6
    {1'b1, 1'b0, 8'd1,  2'd0}   // R7
  };

  task automatic check(input string req, input logic [1:0] exp);
    n_checks++;
    if ({sel_hi, sel_lo} !== exp) begin
      n_fail++;
      $display("FAIL %s: code=%b expected=%b", req, {sel_hi, sel_lo}, exp);
    end
  endtask

  task automatic run(input logic c, input logic p, input int n);
    carrier_ok = c;
    preamble_ok = p;
    repeat (n) @(posedge clk);
    @(negedge clk);
    preamble_ok = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 2'b00);
    rst_n = 1'b1;
    @(negedge clk);   // one edge with carrier low: timer stays zero
    check("R1 after release", 2'b00);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][11], VEC[i][10], int'(VEC[i][9:2]));
      check($sformatf("R2-table vector %0d", i), VEC[i][1:0]);
    end

    // R3: hunt_len 0 acts as 1, R6: lock_periods 0 acts as 1
    hunt_len = '0;
    lock_periods = '0;
    run(1'b1, 1'b0, 3);
    check("R3 zero period", 2'b11);
    run(1'b1, 1'b1, 1);
    check("R5 pulse at period 1", 2'b11);
    run(1'b1, 1'b0, 1);
    check("R6 zero window holds one period", 2'b11);
    run(1'b1, 1'b0, 1);
    check("R7 resume after zero window", 2'b00);

    rst_n = 1'b0;
    hunt_len = PW'(4);
    run(1'b1, 1'b0, 2);
    check("R1 reset midstream", 2'b00);
    rst_n = 1'b1;
    run(1'b1, 1'b0, 3);
    check("R1 timer zero after reset", 2'b00);
    run(1'b1, 1'b0, 1);
    check("R1 first step after reset", 2'b01);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule